// File: doc/BRIEF.md
# Acknowledge-Polling Write-Completion Master

This block is a two-wire bus master sequencer. It waits for a serial memory to finish its internal write cycle. Once the previous write has ended with a stop, the block accepts a command. The command gives the memory's 7-bit device address, says whether the next operation is a write, and carries the byte address that a write would use. The block then probes the memory again and again. Each probe is a start condition followed by the device address with the direction bit at 0, plus a ninth clock in which SDA is released. A memory that is still writing leaves its inputs disabled, so SDA stays high on the ninth clock. The block then closes the bus with a stop and probes again.

When a probe is acknowledged, the next step depends on the command. If the next operation is a read, the block issues a stop and reports completion. If the next operation is a write, it sends the byte address straight away with no stop. It then parks SCL low and hands the held bus to the logic that transfers the data. A poll limit bounds the wait: a typical write cycle is around 5 ms, so the limit is set to cover that time at the chosen bit rate. When the limit is hit without an acknowledge, the block stops and reports a timeout. Bus timing comes from a parameterised quarter-bit divider. SDA is an open-drain pull-down output.

Top module: `ackp_master`

## Requirements
- R1: After reset, and whenever the block is idle and not holding the bus, SCL is high, SDA is released, and busy, done and bus_held are low. After reset poll_count is 0.
- R2: A command is accepted when cmd_valid is high while the block is idle, and busy rises on the next clock. A cmd_valid seen while busy is ignored: it produces no bus activity and does not change poll_count.
- R3: Each probe is a start, then the byte {device address, 0} sent MSB first on eight SCL pulses, then a ninth SCL pulse with SDA released. SDA low on the ninth pulse means acknowledge.
- R4: SDA changes only while SCL is low. The two exceptions are a start (SDA falls while SCL is high) and a stop (SDA rises while SCL is high).
- R5: A probe that is not acknowledged is followed by a stop and then a new probe, until an acknowledge arrives or the limit in R9 is reached.
- R6: An acknowledged probe with a read as the next operation is followed by a stop. The block then pulses done without timeout and returns to the idle bus state of R1.
- R7: An acknowledged probe with a write as the next operation is followed, with no stop, by the 8-bit byte address sent MSB first and a ninth SCL pulse with SDA released. SCL is then parked low with SDA released, done pulses and bus_held is high until the next command is accepted.
- R8: poll_count is the number of probes issued for the current command. It is cleared when a command is accepted and holds its value after done until the next command.
- R9: After MAX_POLLS probes that are not acknowledged, the block issues a stop and then pulses done and timeout in the same cycle. poll_count then reads MAX_POLLS.
- R10: done is high for exactly one clock per command. busy is low in that cycle.
- R11: Within a byte, successive SCL rising edges are 4*QDIV+2 clock cycles apart. The acknowledge level is captured while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Start a polling sequence (taken only when idle) |
| cmd_dev_addr | input | 7 | Device address to probe |
| cmd_write_next | input | 1 | 1: the next operation is a write, so send the byte address after the acknowledge |
| cmd_byte_addr | input | 8 | Byte address sent when cmd_write_next is 1 |
| scl_o | output | 1 | SCL level |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_i | input | 1 | Sampled SDA line level (synchronous to clk) |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | Pulses with done when the poll limit ran out |
| poll_count | output | CNT_W | Probes issued for the current command |
| bus_held | output | 1 | The bus is kept (SCL low) after a write hand-off |

## Verification
A command takes effect on the clock after it is sampled, so busy is checked at the next falling edge. Each bus symbol lasts exactly 4*QDIV+2 clocks, and the bench measures this directly between SCL rising edges within each byte. A memory model records starts, stops and bytes, each with its ninth-clock level, at the moment they appear on the wires. Each record is compared at once with a queue that the command task filled in advance from the busy count and the address. The bench waits for the done pulse, sampling on falling clock edges. In that same cycle it checks timeout, poll_count, bus_held and the line levels. It also checks that the expected queue has already drained, because the last stop edge or the final address acknowledge lands no later than done. One cycle later it confirms that done has dropped and poll_count has held its value.

// File: rtl/ackp_pkg.sv
`timescale 1ns/1ps
package ackp_pkg;
   localparam int BYTE_W = 8;
   localparam int DEV_W  = BYTE_W - 1;
   localparam int BIT_W  = $clog2(BYTE_W);

   typedef enum logic [1:0] {
      SYM_START = 2'd0,
      SYM_BIT   = 2'd1,
      SYM_STOP  = 2'd2,
      SYM_PARK  = 2'd3
   } sym_e;

   typedef enum logic [3:0] {
      ST_IDLE, ST_START, ST_ABIT, ST_AACK, ST_RETRY,
      ST_STOPOK, ST_STOPERR, ST_BBIT, ST_BACK, ST_PARK
   } st_e;
endpackage

// File: rtl/ackp_tick.sv
`timescale 1ns/1ps
module ackp_tick #(
   parameter int QDIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   generate
      if (QDIV == 1) begin : g_full
         assign tick = run;
      end else begin : g_div
         localparam int CW = $clog2(QDIV);
         localparam logic [CW-1:0] LAST = CW'(QDIV - 1);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           cnt <= '0;
            else if (!run)        cnt <= '0;
            else if (cnt == LAST) cnt <= '0;
            else                  cnt <= cnt + 1'b1;
         end
         assign tick = run && (cnt == LAST);
      end
   endgenerate
endmodule

// File: rtl/ackp_phy.sv
`timescale 1ns/1ps
module ackp_phy
   import ackp_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic qtick,
   input  logic go,
   input  sym_e kind,
   input  logic bit_val,
   input  logic sda_in,
   output logic scl,
   output logic sda_low,
   output logic active,
   output logic sym_done,
   output logic rx,
   output sym_e cur_kind
);
   logic [1:0] q;
   logic       b;
   logic       nx_scl, nx_sdal;

   // Line levels for quarter q of the current symbol.
   always_comb begin
      nx_scl  = scl;
      nx_sdal = sda_low;
      case (cur_kind)
         SYM_START: begin
            nx_scl  = 1'b1;
            nx_sdal = (q >= 2'd2);
         end
         SYM_BIT: begin
            nx_scl = (q >= 2'd2);
            if (q != 2'd0) nx_sdal = !b;
         end
         SYM_STOP: begin
            nx_scl = (q >= 2'd2);
            if (q == 2'd1 || q == 2'd2) nx_sdal = 1'b1;
            else if (q == 2'd3)         nx_sdal = 1'b0;
         end
         default: begin
            nx_scl = 1'b0;
            if (q != 2'd0) nx_sdal = 1'b0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl      <= 1'b1;
         sda_low  <= 1'b0;
         active   <= 1'b0;
         sym_done <= 1'b0;
         rx       <= 1'b1;
         q        <= 2'd0;
         b        <= 1'b1;
         cur_kind <= SYM_START;
      end else begin
         sym_done <= 1'b0;
         if (!active && go) begin
            active   <= 1'b1;
            q        <= 2'd0;
            b        <= bit_val;
            cur_kind <= kind;
         end else if (active && qtick) begin
            scl     <= nx_scl;
            sda_low <= nx_sdal;
            q       <= q + 2'd1;
            if (q == 2'd3) begin
               active   <= 1'b0;
               sym_done <= 1'b1;
               rx       <= sda_in;
            end
         end
      end
   end
endmodule

// File: rtl/ackp_seq.sv
`timescale 1ns/1ps
module ackp_seq
   import ackp_pkg::*;
#(
   parameter int MAX_POLLS = 1000,
   parameter int CNT_W     = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [DEV_W-1:0]  cmd_dev,
   input  logic              cmd_wr,
   input  logic [BYTE_W-1:0] cmd_baddr,
   input  logic              sym_done,
   input  logic              sym_active,
   input  logic              rx,
   output logic              sym_go,
   output sym_e              sym_kind,
   output logic              sym_bit,
   output logic              busy,
   output logic              done,
   output logic              timeout,
   output logic [CNT_W-1:0]  poll_count,
   output logic              bus_held
);
   localparam logic [CNT_W-1:0] LIMIT    = CNT_W'(MAX_POLLS);
   localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

   st_e               st;
   logic [BYTE_W-1:0] sh;
   logic [BIT_W-1:0]  n;
   logic              issued, wr_q;
   logic [DEV_W-1:0]  dev_q;
   logic [BYTE_W-1:0] ba_q;

   always_comb begin
      sym_kind = SYM_BIT;
      sym_bit  = 1'b1;
      case (st)
         ST_START:                      sym_kind = SYM_START;
         ST_ABIT, ST_BBIT:              sym_bit  = sh[BYTE_W-1];
         ST_RETRY, ST_STOPOK, ST_STOPERR: sym_kind = SYM_STOP;
         ST_PARK:                       sym_kind = SYM_PARK;
         default: ;
      endcase
      sym_go = (st != ST_IDLE) && !issued && !sym_active;
   end

   assign busy = (st != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_IDLE; sh <= '0; n <= '0; issued <= 1'b0;
         wr_q <= 1'b0; dev_q <= '0; ba_q <= '0;
         poll_count <= '0; done <= 1'b0; timeout <= 1'b0; bus_held <= 1'b0;
      end else begin
         done    <= 1'b0;
         timeout <= 1'b0;
         if (sym_go) issued <= 1'b1;
         if (st == ST_IDLE) begin
            if (cmd_valid) begin
               st         <= ST_START;
               dev_q      <= cmd_dev;
               wr_q       <= cmd_wr;
               ba_q       <= cmd_baddr;
               poll_count <= '0;
               bus_held   <= 1'b0;
            end
         end else if (sym_done) begin
            issued <= 1'b0;
            case (st)
               ST_START: begin
                  st <= ST_ABIT;
                  sh <= {dev_q, 1'b0};
                  n  <= LAST_BIT;
                  if (poll_count != LIMIT) poll_count <= poll_count + 1'b1;
               end
               ST_ABIT, ST_BBIT: begin
                  if (n == '0) st <= (st == ST_ABIT) ? ST_AACK : ST_BACK;
                  else begin
                     sh <= sh << 1;
                     n  <= n - 1'b1;
                  end
               end
               ST_AACK: begin
                  if (!rx) begin
                     if (wr_q) begin
                        st <= ST_BBIT;
                        sh <= ba_q;
                        n  <= LAST_BIT;
                     end else st <= ST_STOPOK;
                  end else st <= (poll_count == LIMIT) ? ST_STOPERR : ST_RETRY;
               end
               ST_RETRY:  st <= ST_START;
               ST_BACK:   st <= ST_PARK;
               ST_STOPOK: begin st <= ST_IDLE; done <= 1'b1; end
               ST_STOPERR: begin st <= ST_IDLE; done <= 1'b1; timeout <= 1'b1; end
               ST_PARK:   begin st <= ST_IDLE; done <= 1'b1; bus_held <= 1'b1; end
               default:   st <= ST_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/ackp_master.sv
`timescale 1ns/1ps
module ackp_master
   import ackp_pkg::*;
#(
   parameter int QDIV      = 125,
   parameter int MAX_POLLS = 1000,
   parameter int CNT_W     = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [6:0]        cmd_dev_addr,
   input  logic              cmd_write_next,
   input  logic [7:0]        cmd_byte_addr,
   output logic              scl_o,
   output logic              sda_pull_o,
   input  logic              sda_i,
   output logic              busy,
   output logic              done,
   output logic              timeout,
   output logic [CNT_W-1:0]  poll_count,
   output logic              bus_held
);
   generate
      if (QDIV < 1) begin : g_bad_div
         $error("QDIV must be at least 1");
      end
      if (CNT_W < 2) begin : g_bad_cw
         $error("CNT_W must be at least 2");
      end
      if (MAX_POLLS < 1 || MAX_POLLS >= (2 ** CNT_W)) begin : g_bad_lim
         $error("MAX_POLLS must lie in 1 .. 2**CNT_W-1");
      end
   endgenerate

   logic qtick, eng_active, eng_done, eng_rx, seq_go, seq_bit;
   sym_e seq_kind, eng_kind;

   ackp_tick #(.QDIV(QDIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .run(eng_active), .tick(qtick)
   );

   ackp_phy u_phy (
      .clk(clk), .rst_n(rst_n), .qtick(qtick), .go(seq_go),
      .kind(seq_kind), .bit_val(seq_bit), .sda_in(sda_i),
      .scl(scl_o), .sda_low(sda_pull_o), .active(eng_active),
      .sym_done(eng_done), .rx(eng_rx), .cur_kind(eng_kind)
   );

   ackp_seq #(.MAX_POLLS(MAX_POLLS), .CNT_W(CNT_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid),
      .cmd_dev(cmd_dev_addr), .cmd_wr(cmd_write_next), .cmd_baddr(cmd_byte_addr),
      .sym_done(eng_done), .sym_active(eng_active), .rx(eng_rx),
      .sym_go(seq_go), .sym_kind(seq_kind), .sym_bit(seq_bit),
      .busy(busy), .done(done), .timeout(timeout),
      .poll_count(poll_count), .bus_held(bus_held)
   );
endmodule

// File: rtl/ackp_master_chk.sv
`timescale 1ns/1ps
module ackp_master_chk
   import ackp_pkg::*;
#(
   parameter int MAX_POLLS = 1000,
   parameter int CNT_W     = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             scl,
   input logic             sda_pull,
   input logic             busy,
   input logic             done,
   input logic             timeout,
   input logic [CNT_W-1:0] poll_count,
   input logic             bus_held,
   input logic [1:0]       kind
);
   a_r4_sda_moves_with_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      (scl && $past(scl) && (sda_pull != $past(sda_pull)))
         |-> (kind == SYM_START || kind == SYM_STOP));

   a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r10_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   a_r9_timeout_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      timeout |-> done);

   a_r1_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !bus_held) |-> (scl && !sda_pull));

   a_r7_held_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      bus_held |-> (!scl && !sda_pull));

   a_r8_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      poll_count <= CNT_W'(MAX_POLLS));

   a_r8_count_held_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && $past(!busy)) |-> $stable(poll_count));
endmodule

bind ackp_master ackp_master_chk #(.MAX_POLLS(MAX_POLLS), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .scl(scl_o), .sda_pull(sda_pull_o),
   .busy(busy), .done(done), .timeout(timeout), .poll_count(poll_count),
   .bus_held(bus_held), .kind(eng_kind)
);

// File: tb/tb_ackp_master.sv
`timescale 1ns/1ps
module tb_ackp_master;
   localparam int QDIV = 3;
   localparam int MAXP = 4;
   localparam int CW   = 16;
   localparam logic [6:0] MEM = 7'h50;
   localparam longint BITNS = (4 * QDIV + 2) * 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;   // 250 MHz

   logic          cmd_valid = 1'b0;
   logic [6:0]    cmd_dev = '0;
   logic          cmd_wr = 1'b0;
   logic [7:0]    cmd_ba = '0;
   logic          scl, sda_pull, busy, done, timeout, bus_held;
   logic [CW-1:0] poll_count;
   logic          slv_pull = 1'b0;
   wire           sda_line;
   assign sda_line = !(sda_pull || slv_pull);

   ackp_master #(.QDIV(QDIV), .MAX_POLLS(MAXP), .CNT_W(CW)) dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_dev_addr(cmd_dev),
      .cmd_write_next(cmd_wr), .cmd_byte_addr(cmd_ba), .scl_o(scl),
      .sda_pull_o(sda_pull), .sda_i(sda_line), .busy(busy), .done(done),
      .timeout(timeout), .poll_count(poll_count), .bus_held(bus_held)
   );

   int total = 0;
   int bad = 0;
   bit finished = 0;

   task automatic chk(bit ok, string req, string what, longint act, longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // Scoreboard items: [10:9] 1=start 2=byte 3=stop, [8] ninth-clock level, [7:0] byte
   typedef logic [10:0] item_t;
   item_t expq[$];

   task automatic observe(item_t got);
      item_t e;
      if (expq.size() == 0) chk(1'b0, "R2", "unexpected bus event", got, 0);
      else begin
         e = expq.pop_front();
         chk(got == e, (e[10:9] == 2'd2) ? "R3" : "R4", "bus event", got, e);
      end
   endtask

   // Memory model and monitor
   int           busy_left = 0;
   int           bitn = 0;
   logic [7:0]   sh = '0;
   bit           first_byte = 0;
   bit           sel = 0;
   longint       last_rise = 0;

   always @(negedge sda_line) if (rst_n && scl === 1'b1) begin
      bitn = 0; first_byte = 1; sel = 0;
      observe({2'd1, 9'd0});
   end

   always @(posedge sda_line) if (rst_n && scl === 1'b1) begin
      bitn = 0; sel = 0;
      observe({2'd3, 9'd0});
   end

   always @(posedge scl) if (rst_n) begin
      if (bitn > 0) chk(($time - last_rise) == BITNS, "R11", "bit period", $time - last_rise, BITNS);
      last_rise = $time;
      if (bitn < 8) sh = {sh[6:0], sda_line};
      bitn++;
      if (bitn == 9) begin
         observe({2'd2, sda_line, sh});
         bitn = 0;
         first_byte = 0;
      end
   end

   always @(negedge scl) if (rst_n) begin
      if (bitn == 8) begin
         if (first_byte) begin
            if (sh[7:1] == MEM && sh[0] == 1'b0) begin
               if (busy_left == 0) begin slv_pull = 1'b1; sel = 1; end
               else busy_left--;
            end
         end else if (sel) slv_pull = 1'b1;
      end else slv_pull = 1'b0;
   end

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      chk(1'b0, "R10", "watchdog expired", 0, 1);
      summary();
   end

   task automatic run(logic [6:0] dev, bit wr, logic [7:0] ba, int busy_n, bit poke);
      int nacks = (dev == MEM) ? busy_n : 1000;
      int probes = (nacks >= MAXP) ? MAXP : nacks + 1;
      bit ok = (nacks < MAXP);
      logic [CW-1:0] pc_seen;
      busy_left = busy_n;
      for (int p = 0; p < probes; p++) begin
         expq.push_back({2'd1, 9'd0});
         expq.push_back({2'd2, (p != nacks), dev, 1'b0});
         if (p != nacks)  expq.push_back({2'd3, 9'd0});
         else if (wr)     expq.push_back({2'd2, 1'b0, ba});
         else             expq.push_back({2'd3, 9'd0});
      end
      @(negedge clk);
      cmd_dev = dev; cmd_wr = wr; cmd_ba = ba; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      chk(busy == 1'b1, "R2", "busy after accept", busy, 1);
      if (poke) begin
         repeat (40) @(negedge clk);
         cmd_dev = 7'h11; cmd_wr = 1'b1; cmd_valid = 1'b1;   // R2: must be ignored
         @(negedge clk);
         cmd_valid = 1'b0;
      end
      while (!done) @(negedge clk);
      chk(busy == 1'b0, "R10", "busy at done", busy, 0);
      chk(timeout == !ok, "R9", "timeout flag", timeout, !ok);
      chk(poll_count == CW'(probes), "R8", "poll count", poll_count, probes);
      if (ok && nacks > 0) chk(poll_count == CW'(nacks + 1), "R5", "retries", poll_count, nacks + 1);
      chk(bus_held == (ok && wr), "R7", "bus_held", bus_held, ok && wr);
      if (ok && wr) chk(scl == 1'b0 && sda_pull == 1'b0, "R7", "parked lines", {scl, sda_pull}, 0);
      else chk(scl == 1'b1 && sda_pull == 1'b0, "R6", "idle lines after stop", {scl, sda_pull}, 2);
      chk(expq.size() == 0, "R3", "pending bus events", expq.size(), 0);
      pc_seen = poll_count;
      @(negedge clk);
      chk(done == 1'b0, "R10", "done width", done, 0);
      chk(poll_count == pc_seen, "R8", "count held", poll_count, pc_seen);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(scl == 1'b1 && sda_pull == 1'b0, "R1", "reset lines", {scl, sda_pull}, 2);
      chk({busy, done, bus_held} == 3'b000, "R1", "reset flags", {busy, done, bus_held}, 0);
      chk(poll_count == '0, "R1", "reset count", poll_count, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      run(MEM, 1'b0, 8'h00, 0, 1'b0);   // R6 immediate ack
      run(MEM, 1'b0, 8'h00, 2, 1'b0);   // R5 two busy probes
      run(MEM, 1'b1, 8'hA5, 1, 1'b0);   // R7 write hand-off
      run(MEM, 1'b1, 8'h3C, 0, 1'b0);   // R7 from held bus
      run(MEM, 1'b0, 8'h00, 3, 1'b1);   // R9 boundary: ack on last allowed probe, R2 poke
      run(7'h2B, 1'b0, 8'h00, 0, 1'b0); // R9 absent device
      run(MEM, 1'b0, 8'h00, 4, 1'b0);   // R9 busy exceeds limit
      repeat (20) @(negedge clk);
      chk(scl == 1'b1 && sda_pull == 1'b0 && !busy, "R1", "final idle", {busy, scl, sda_pull}, 2);
      chk(expq.size() == 0, "R2", "stray events", expq.size(), 0);
      summary();
   end
endmodule